// File: doc/BRIEF.md
# Outstanding Transaction Regulating Bridge

This block sits on a single clock between an upstream AXI-style slave port and a downstream AXI-style master port. Address, data and response channels pass straight through at equal data widths. The block counts the reads and writes that are in flight toward the downstream side. When a read limit, a write limit or a combined limit is reached, it holds the address-channel ready low. A caller keeps its request presented, and the request is taken once a transaction retires.

A run-time input restricts the downstream side to one transaction in flight. The block also checks each incoming address against a fixed reachable window. A request that misses the window is never forwarded. The block answers it locally with a decode-error response, and the downstream address is the low part of the upstream address.

Two conditions are assumed of the upstream side. It presents the write data of a request no earlier than that request's address. It keeps a stalled request steady until that request is accepted.

Top module: `otr_bridge`

## Requirements
- R1: The downstream address equals the low 30 bits of the 32-bit upstream address. IDs (12 bits), burst length, write data and strobes, and read and write responses pass through unchanged in both directions.
- R2: After a synchronous active-low reset, all in-flight counts are zero. No valid is driven on the downstream address channels or on the upstream response channels, and a full set of reads can be accepted.
- R3: At most RD_MAX reads (default 16) are in flight. A read counts from its downstream address handshake and retires only on a read beat with last set; a beat with last clear retires nothing.
- R4: At most WR_MAX writes (default 16) are in flight. A write counts from its downstream address handshake and retires on its write-response handshake.
- R5: At most TOT_MAX transactions (default 32), reads plus writes, are in flight. When a read and a write arrive together, the read is considered first.
- R6: While single_issue is 1, a new read or write is accepted only when nothing is in flight. When a read and a write are presented in the same cycle with nothing in flight, only the read is accepted.
- R7: A request whose address is at or above 0x3FFF0000 is never forwarded downstream. A request at 0x3FFEFFFC is forwarded.
- R8: An out-of-window read is accepted only when no forwarded read is in flight. It is answered with exactly one beat carrying response code 2'b11 (decode error), last set, zero data and the request's ID.
- R9: The write data of an out-of-window write is accepted upstream and not forwarded until its last beat. After that beat, exactly one write response with code 2'b11 and the request's ID is returned.
- R10: A request held off by a limit is not lost. While it is stalled its ready stays low, and it is forwarded with its own ID once a slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| single_issue | input | 1 | 1: one transaction in flight downstream at most |
| s_awid | input | IDW | Upstream write ID |
| s_awaddr | input | SAW | Upstream write byte address |
| s_awlen | input | LENW | Upstream write burst length |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_wdata | input | DW | Upstream write data |
| s_wstrb | input | DW/8 | Upstream write strobes |
| s_wlast | input | 1 | Upstream last write beat |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_bid | output | IDW | Upstream write response ID |
| s_bresp | output | 2 | Upstream write response code |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_arid | input | IDW | Upstream read ID |
| s_araddr | input | SAW | Upstream read byte address |
| s_arlen | input | LENW | Upstream read burst length |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_rid | output | IDW | Upstream read ID |
| s_rdata | output | DW | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| s_rlast | output | 1 | Upstream last read beat |
| s_rvalid | output | 1 | Upstream read valid |
| s_rready | input | 1 | Upstream read ready |
| m_awid | output | IDW | Downstream write ID |
| m_awaddr | output | MAW | Downstream write byte address |
| m_awlen | output | LENW | Downstream write burst length |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_wdata | output | DW | Downstream write data |
| m_wstrb | output | DW/8 | Downstream write strobes |
| m_wlast | output | 1 | Downstream last write beat |
| m_wvalid | output | 1 | Downstream write data valid |
| m_wready | input | 1 | Downstream write data ready |
| m_bid | input | IDW | Downstream write response ID |
| m_bresp | input | 2 | Downstream write response code |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_arid | output | IDW | Downstream read ID |
| m_araddr | output | MAW | Downstream read byte address |
| m_arlen | output | LENW | Downstream read burst length |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_rid | input | IDW | Downstream read ID |
| m_rdata | input | DW | Downstream read data |
| m_rresp | input | 2 | Downstream read response code |
| m_rlast | input | 1 | Downstream last read beat |
| m_rvalid | input | 1 | Downstream read valid |
| m_rready | output | 1 | Downstream read ready |

## Verification
The bench uses small limits (4 reads, 4 writes, 6 total) so that every limit can be reached. It sweeps the number of reads in flight from zero past the read limit, and expects acceptance exactly while the count is below the limit. With reads parked at the read limit, writes are issued to show the combined limit cutting in before the write limit. Writes are then issued alone to reach the write limit on its own. A read beat with last clear is returned while a request is stalled, which separates retiring on the last beat from retiring on any beat. Addresses just below and at the window limit show where forwarding stops. Same-cycle read and write requests in single-issue mode check the read-first order.

// File: rtl/otr_pkg.sv
// Package otr_pkg: shared constants for the outstanding transaction
// regulating bridge. Assumes a two-bit response code on both ports.
package otr_pkg;
    localparam logic [1:0] RESP_DECERR = 2'b11;
    localparam int         CH_RD       = 0;
    localparam int         CH_WR       = 1;
    localparam int         N_CH        = 2;

    typedef enum logic [1:0] {
        WE_IDLE  = 2'd0,
        WE_DRAIN = 2'd1,
        WE_RESP  = 2'd2
    } werr_state_t;
endpackage

// File: rtl/otr_cnt.sv
// Module otr_cnt: up/down counter of transactions in flight on one
// direction. Assumes inc and dec never take it out of its range, which
// the gating in the top guarantees.
module otr_cnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt
);
    // Track the in-flight count; equal inc and dec leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && !dec)
            cnt <= cnt + 1'b1;
        else if (dec && !inc)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/otr_decerr.sv
// Module otr_decerr: local responder for requests outside the reachable
// window. One read error and one write error can be pending at a time.
// Assumes the top forces the matching upstream valid/ready high while busy,
// so a handshake here only needs the upstream side's signal.
module otr_decerr
    import otr_pkg::*;
#(
    parameter int IDW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_start,
    input  logic [IDW-1:0] rd_id_in,
    input  logic           s_rready,
    input  logic           wr_start,
    input  logic [IDW-1:0] wr_id_in,
    input  logic           s_wvalid,
    input  logic           s_wlast,
    input  logic           s_bready,
    output logic           rd_busy,
    output logic [IDW-1:0] rd_id,
    output logic           wr_drain,
    output logic           wr_resp,
    output logic [IDW-1:0] wr_id
);
    werr_state_t wst;

    // Hold one pending read error beat until the upstream side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy <= 1'b0;
            rd_id   <= '0;
        end else if (rd_start) begin
            rd_busy <= 1'b1;
            rd_id   <= rd_id_in;
        end else if (rd_busy && s_rready) begin
            rd_busy <= 1'b0;
        end
    end

    // Sequence a write error: swallow data up to the last beat, then respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst   <= WE_IDLE;
            wr_id <= '0;
        end else begin
            case (wst)
                WE_IDLE:  if (wr_start) begin
                              wst   <= WE_DRAIN;
                              wr_id <= wr_id_in;
                          end
                WE_DRAIN: if (s_wvalid && s_wlast) wst <= WE_RESP;
                WE_RESP:  if (s_bready) wst <= WE_IDLE;
                default:  wst <= WE_IDLE;
            endcase
        end
    end

    assign wr_drain = (wst == WE_DRAIN);
    assign wr_resp  = (wst == WE_RESP);
endmodule

// File: rtl/otr_bridge.sv
// Module otr_bridge: single-clock pass-through that limits reads, writes and
// their sum in flight downstream, offers a one-in-flight mode, blocks
// addresses outside the window and answers them with a decode error.
// Assumes upstream write data never precedes its address and stalled
// requests are held steady.
module otr_bridge
    import otr_pkg::*;
#(
    parameter int             IDW       = 12,
    parameter int             DW        = 32,
    parameter int             SAW       = 32,
    parameter int             MAW       = 30,
    parameter int             LENW      = 8,
    parameter int             RD_MAX    = 16,
    parameter int             WR_MAX    = 16,
    parameter int             TOT_MAX   = 32,
    parameter logic [SAW-1:0] WIN_LIMIT = 32'h3FFF_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            single_issue,
    input  logic [IDW-1:0]  s_awid,
    input  logic [SAW-1:0]  s_awaddr,
    input  logic [LENW-1:0] s_awlen,
    input  logic            s_awvalid,
    output logic            s_awready,
    input  logic [DW-1:0]   s_wdata,
    input  logic [DW/8-1:0] s_wstrb,
    input  logic            s_wlast,
    input  logic            s_wvalid,
    output logic            s_wready,
    output logic [IDW-1:0]  s_bid,
    output logic [1:0]      s_bresp,
    output logic            s_bvalid,
    input  logic            s_bready,
    input  logic [IDW-1:0]  s_arid,
    input  logic [SAW-1:0]  s_araddr,
    input  logic [LENW-1:0] s_arlen,
    input  logic            s_arvalid,
    output logic            s_arready,
    output logic [IDW-1:0]  s_rid,
    output logic [DW-1:0]   s_rdata,
    output logic [1:0]      s_rresp,
    output logic            s_rlast,
    output logic            s_rvalid,
    input  logic            s_rready,
    output logic [IDW-1:0]  m_awid,
    output logic [MAW-1:0]  m_awaddr,
    output logic [LENW-1:0] m_awlen,
    output logic            m_awvalid,
    input  logic            m_awready,
    output logic [DW-1:0]   m_wdata,
    output logic [DW/8-1:0] m_wstrb,
    output logic            m_wlast,
    output logic            m_wvalid,
    input  logic            m_wready,
    input  logic [IDW-1:0]  m_bid,
    input  logic [1:0]      m_bresp,
    input  logic            m_bvalid,
    output logic            m_bready,
    output logic [IDW-1:0]  m_arid,
    output logic [MAW-1:0]  m_araddr,
    output logic [LENW-1:0] m_arlen,
    output logic            m_arvalid,
    input  logic            m_arready,
    input  logic [IDW-1:0]  m_rid,
    input  logic [DW-1:0]   m_rdata,
    input  logic [1:0]      m_rresp,
    input  logic            m_rlast,
    input  logic            m_rvalid,
    output logic            m_rready
);
    localparam int          CW     = $clog2(RD_MAX + WR_MAX + 2);
    localparam logic [CW-1:0] RD_LIM  = CW'(RD_MAX);
    localparam logic [CW-1:0] WR_LIM  = CW'(WR_MAX);
    localparam logic [CW-1:0] TOT_LIM = CW'(TOT_MAX);

    logic [N_CH-1:0] c_inc, c_dec;
    logic [CW-1:0]   c_val [N_CH];
    logic [CW-1:0]   rd_cnt, wr_cnt, tot;
    logic            ar_hit, aw_hit, ar_gate, aw_gate, ar_fwd_try;
    logic            err_rd_busy, err_wr_drain, err_wr_resp;
    logic [IDW-1:0]  err_rid, err_wid;

    // One in-flight counter per direction.
    for (genvar k = 0; k < N_CH; k++) begin : g_cnt
        otr_cnt #(.CW(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .inc(c_inc[k]), .dec(c_dec[k]), .cnt(c_val[k])
        );
    end

    assign rd_cnt = c_val[CH_RD];
    assign wr_cnt = c_val[CH_WR];
    assign tot    = rd_cnt + wr_cnt;

    assign c_inc[CH_RD] = m_arvalid && m_arready;
    assign c_dec[CH_RD] = m_rvalid && m_rready && m_rlast;
    assign c_inc[CH_WR] = m_awvalid && m_awready;
    assign c_dec[CH_WR] = m_bvalid && m_bready;

    // Decide whether each address channel may accept; reads go first.
    always_comb begin
        ar_hit     = s_araddr < WIN_LIMIT;
        aw_hit     = s_awaddr < WIN_LIMIT;
        ar_gate    = !err_rd_busy && (rd_cnt < RD_LIM) && (tot < TOT_LIM)
                     && (!single_issue || tot == '0);
        ar_fwd_try = s_arvalid && ar_hit && ar_gate;
        aw_gate    = !err_wr_drain && !err_wr_resp && (wr_cnt < WR_LIM)
                     && ((tot + CW'(ar_fwd_try)) < TOT_LIM)
                     && (!single_issue || (tot == '0 && !ar_fwd_try));
    end

    // Read address channel.
    assign m_arvalid = ar_fwd_try;
    assign m_arid    = s_arid;
    assign m_araddr  = s_araddr[MAW-1:0];
    assign m_arlen   = s_arlen;
    assign s_arready = ar_gate && (ar_hit ? m_arready : (rd_cnt == '0));

    // Write address channel.
    assign m_awvalid = s_awvalid && aw_hit && aw_gate;
    assign m_awid    = s_awid;
    assign m_awaddr  = s_awaddr[MAW-1:0];
    assign m_awlen   = s_awlen;
    assign s_awready = aw_gate && (aw_hit ? m_awready : (wr_cnt == '0));

    otr_decerr #(.IDW(IDW)) u_err (
        .clk(clk), .rst_n(rst_n),
        .rd_start(s_arvalid && s_arready && !ar_hit), .rd_id_in(s_arid),
        .s_rready(s_rready),
        .wr_start(s_awvalid && s_awready && !aw_hit), .wr_id_in(s_awid),
        .s_wvalid(s_wvalid), .s_wlast(s_wlast), .s_bready(s_bready),
        .rd_busy(err_rd_busy), .rd_id(err_rid),
        .wr_drain(err_wr_drain), .wr_resp(err_wr_resp), .wr_id(err_wid)
    );

    // Read data: local error beat overrides the downstream path.
    always_comb begin
        s_rvalid = err_rd_busy ? 1'b1        : m_rvalid;
        s_rid    = err_rd_busy ? err_rid     : m_rid;
        s_rdata  = err_rd_busy ? '0          : m_rdata;
        s_rresp  = err_rd_busy ? RESP_DECERR : m_rresp;
        s_rlast  = err_rd_busy ? 1'b1        : m_rlast;
        m_rready = !err_rd_busy && s_rready;
    end

    // Write data and response: drain or answer locally during a write error.
    always_comb begin
        m_wdata  = s_wdata;
        m_wstrb  = s_wstrb;
        m_wlast  = s_wlast;
        m_wvalid = s_wvalid && !err_wr_drain;
        s_wready = err_wr_drain ? 1'b1 : m_wready;
        s_bvalid = err_wr_resp ? 1'b1        : m_bvalid;
        s_bid    = err_wr_resp ? err_wid     : m_bid;
        s_bresp  = err_wr_resp ? RESP_DECERR : m_bresp;
        m_bready = !err_wr_resp && s_bready;
    end
endmodule

// File: rtl/otr_bridge_chk.sv
// Module otr_bridge_chk: properties of otr_bridge, attached by bind.
// Assumes the counters and the address inputs of the bound instance.
module otr_bridge_chk #(
    parameter int             CW        = 6,
    parameter int             SAW       = 32,
    parameter int             RD_MAX    = 16,
    parameter int             WR_MAX    = 16,
    parameter int             TOT_MAX   = 32,
    parameter logic [SAW-1:0] WIN_LIMIT = 32'h3FFF_0000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           single_issue,
    input logic [CW-1:0]  rd_cnt,
    input logic [CW-1:0]  wr_cnt,
    input logic           m_arvalid,
    input logic           m_awvalid,
    input logic [SAW-1:0] s_araddr,
    input logic [SAW-1:0] s_awaddr
);
    // R3
    rd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CW'(RD_MAX));
    // R4
    wr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CW'(WR_MAX));
    // R5
    tot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt + wr_cnt) <= CW'(TOT_MAX));
    // R6
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_issue && (rd_cnt != '0 || wr_cnt != '0)) |-> !(m_arvalid || m_awvalid));
    // R7
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (s_araddr < WIN_LIMIT));
    // R7
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (s_awaddr < WIN_LIMIT));
endmodule

bind otr_bridge otr_bridge_chk #(
    .CW(CW), .SAW(SAW), .RD_MAX(RD_MAX), .WR_MAX(WR_MAX),
    .TOT_MAX(TOT_MAX), .WIN_LIMIT(WIN_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .single_issue(single_issue),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .m_arvalid(m_arvalid), .m_awvalid(m_awvalid),
    .s_araddr(s_araddr), .s_awaddr(s_awaddr)
);

// File: tb/sim_otr_bridge.sv
`timescale 1ns/1ps
module sim_otr_bridge;
    localparam int IDW = 12, DW = 32, NRD = 4, NWR = 4, NTOT = 6;

    logic clk = 1'b0, rst_n = 1'b0, single_issue = 1'b0;
    logic [IDW-1:0] s_awid = '0, s_arid = '0, s_bid, s_rid, m_awid, m_arid;
    logic [IDW-1:0] m_bid = '0, m_rid = '0;
    logic [31:0] s_awaddr = '0, s_araddr = '0;
    logic [29:0] m_awaddr, m_araddr;
    logic [7:0] s_awlen = '0, s_arlen = '0, m_awlen, m_arlen;
    logic s_awvalid = 0, s_awready, s_wlast = 0, s_wvalid = 0, s_wready;
    logic s_bvalid, s_bready = 1, s_arvalid = 0, s_arready, s_rlast, s_rvalid, s_rready = 1;
    logic [DW-1:0] s_wdata = '0, s_rdata, m_wdata, m_rdata = '0;
    logic [3:0] s_wstrb = '0, m_wstrb;
    logic [1:0] s_bresp, s_rresp, m_bresp = 0, m_rresp = 0;
    logic m_awvalid, m_awready = 1, m_wlast, m_wvalid, m_wready = 1;
    logic m_bvalid = 0, m_bready, m_arvalid, m_arready = 1, m_rlast = 0, m_rvalid = 0, m_rready;

    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    otr_bridge #(.RD_MAX(NRD), .WR_MAX(NWR), .TOT_MAX(NTOT)) u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ar_try(input logic [31:0] a, input logic [IDW-1:0] id, output logic acc);
        @(negedge clk); s_arvalid = 1; s_araddr = a; s_arid = id; s_arlen = 8'd3; #1;
        acc = s_arready;
        @(posedge clk); #1; s_arvalid = 0;
    endtask

    task automatic aw_try(input logic [31:0] a, input logic [IDW-1:0] id, output logic acc);
        @(negedge clk); s_awvalid = 1; s_awaddr = a; s_awid = id; s_awlen = 8'd1; #1;
        acc = s_awready;
        @(posedge clk); #1; s_awvalid = 0;
    endtask

    task automatic r_beat(input logic [IDW-1:0] id, input logic last);
        @(negedge clk); m_rvalid = 1; m_rid = id; m_rlast = last;
        m_rdata = 32'hD000_0000 | 32'(id); m_rresp = 2'b01; #1;
        chk("R1", "r id through", 64'(s_rid), 64'(id));
        chk("R1", "r data through", 64'(s_rdata), 64'(32'hD000_0000 | 32'(id)));
        @(posedge clk); #1; m_rvalid = 0; m_rlast = 0;
    endtask

    task automatic b_beat(input logic [IDW-1:0] id);
        @(negedge clk); m_bvalid = 1; m_bid = id; m_bresp = 2'b00; #1;
        chk("R1", "b id through", 64'(s_bid), 64'(id));
        @(posedge clk); #1; m_bvalid = 0;
    endtask

    initial begin
        #(200000 * 8);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic acc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R2: idle outputs after reset
        @(negedge clk); #1;
        chk("R2", "m_arvalid", 64'(m_arvalid), 0);
        chk("R2", "m_awvalid", 64'(m_awvalid), 0);
        chk("R2", "s_rvalid", 64'(s_rvalid), 0);
        chk("R2", "s_bvalid", 64'(s_bvalid), 0);

        // R1: narrowing and ID pass-through
        @(negedge clk); s_arvalid = 1; s_araddr = 32'h2ABC_0010; s_arid = 12'h9F1; #1;
        chk("R1", "m_araddr", 64'(m_araddr), 64'(30'h2ABC_0010));
        chk("R1", "m_arid", 64'(m_arid), 64'h9F1);
        s_arvalid = 0;

        // R2/R3: sweep read count past the limit
        for (int i = 0; i < NRD + 2; i++) begin
            ar_try(32'h0000_1000 + 32'(i * 64), 12'(i), acc);
            chk((i < NRD) ? "R2" : "R3", "read accept", 64'(acc), 64'(i < NRD));
        end

        // R10/R3: stalled read survives, partial beat retires nothing
        @(negedge clk); s_arvalid = 1; s_araddr = 32'h0000_8000; s_arid = 12'h009; #1;
        chk("R10", "stalled ready", 64'(s_arready), 0);
        r_beat(12'h000, 1'b0);
        @(negedge clk); #1;
        chk("R3", "no retire on non-last", 64'(s_arready), 0);
        r_beat(12'h000, 1'b1);
        @(negedge clk); #1;
        chk("R3", "retire on last", 64'(s_arready), 1);
        chk("R10", "stalled id forwarded", 64'(m_arid), 64'h009);
        chk("R10", "stalled forwarded", 64'(m_arvalid), 1);
        @(posedge clk); #1; s_arvalid = 0;
        for (int i = 0; i < NRD; i++) r_beat(12'(i + 1), 1'b1);

        // R5: reads at limit, combined limit bounds writes
        for (int i = 0; i < NRD; i++) ar_try(32'h100 + 32'(i), 12'(i), acc);
        for (int i = 0; i < 3; i++) begin
            aw_try(32'h0200_0000, 12'(16 + i), acc);
            chk("R5", "write under total", 64'(acc), 64'(i < NTOT - NRD));
        end
        for (int i = 0; i < NRD; i++) r_beat(12'(i), 1'b1);

        // R4: write limit alone, retire on B
        for (int i = 0; i < 3; i++) begin
            aw_try(32'h0300_0000, 12'(32 + i), acc);
            chk("R4", "write under limit", 64'(acc), 64'(i < NWR - 2));
        end
        @(negedge clk); s_wvalid = 1; s_wdata = 32'hCAFE_0001; s_wstrb = 4'hA; s_wlast = 1; #1;
        chk("R1", "w forwarded", 64'(m_wvalid), 1);
        chk("R1", "w data", 64'(m_wdata), 64'hCAFE_0001);
        @(posedge clk); #1; s_wvalid = 0; s_wlast = 0;
        b_beat(12'h010);
        aw_try(32'h0300_0100, 12'h040, acc);
        chk("R4", "accept after B", 64'(acc), 1);
        aw_try(32'h0300_0200, 12'h041, acc);
        chk("R4", "full again", 64'(acc), 0);
        for (int i = 0; i < NWR; i++) b_beat(12'(i));

        // R6: single-issue mode
        single_issue = 1;
        ar_try(32'h500, 12'h050, acc);
        chk("R6", "first read", 64'(acc), 1);
        ar_try(32'h504, 12'h051, acc);
        chk("R6", "second read blocked", 64'(acc), 0);
        aw_try(32'h600, 12'h052, acc);
        chk("R6", "write blocked", 64'(acc), 0);
        r_beat(12'h050, 1'b1);
        aw_try(32'h600, 12'h053, acc);
        chk("R6", "write after retire", 64'(acc), 1);
        b_beat(12'h053);
        @(negedge clk); s_arvalid = 1; s_araddr = 32'h700; s_awvalid = 1; s_awaddr = 32'h800; #1;
        chk("R6", "same-cycle read", 64'(s_arready), 1);
        chk("R6", "same-cycle write", 64'(s_awready), 0);
        @(posedge clk); #1; s_arvalid = 0; s_awvalid = 0;
        r_beat(12'h000, 1'b1);
        single_issue = 0;

        // R7/R8: window edges and local read error
        @(negedge clk); s_arvalid = 1; s_araddr = 32'h3FFE_FFFC; s_arid = 12'h011; #1;
        chk("R7", "edge forwarded", 64'(m_arvalid), 1);
        @(posedge clk); #1; s_arvalid = 0;
        r_beat(12'h011, 1'b1);
        @(negedge clk); s_arvalid = 1; s_araddr = 32'h3FFF_0000; s_arid = 12'hABC; #1;
        chk("R7", "limit not forwarded", 64'(m_arvalid), 0);
        chk("R8", "error read accepted", 64'(s_arready), 1);
        @(posedge clk); #1; s_arvalid = 0;
        @(negedge clk); #1;
        chk("R8", "err rvalid", 64'(s_rvalid), 1);
        chk("R8", "err rresp", 64'(s_rresp), 3);
        chk("R8", "err rlast", 64'(s_rlast), 1);
        chk("R8", "err rid", 64'(s_rid), 64'hABC);
        chk("R8", "err rdata", 64'(s_rdata), 0);
        @(negedge clk); #1;
        chk("R8", "single beat", 64'(s_rvalid), 0);
        ar_try(32'h900, 12'h012, acc);
        ar_try(32'h8000_0000, 12'h013, acc);
        chk("R8", "error read waits", 64'(acc), 0);
        r_beat(12'h012, 1'b1);

        // R7/R9: local write error
        @(negedge clk); s_awvalid = 1; s_awaddr = 32'hFFFF_FFF0; s_awid = 12'h5A5; #1;
        chk("R7", "write not forwarded", 64'(m_awvalid), 0);
        chk("R9", "error write accepted", 64'(s_awready), 1);
        @(posedge clk); #1; s_awvalid = 0;
        for (int b = 0; b < 2; b++) begin
            @(negedge clk); s_wvalid = 1; s_wlast = (b == 1); #1;
            chk("R9", "drain ready", 64'(s_wready), 1);
            chk("R9", "drain not forwarded", 64'(m_wvalid), 0);
            chk("R9", "no early B", 64'(s_bvalid), 0);
            @(posedge clk); #1; s_wvalid = 0; s_wlast = 0;
        end
        @(negedge clk); #1;
        chk("R9", "err bvalid", 64'(s_bvalid), 1);
        chk("R9", "err bresp", 64'(s_bresp), 3);
        chk("R9", "err bid", 64'(s_bid), 64'h5A5);
        @(negedge clk); #1;
        chk("R9", "single B", 64'(s_bvalid), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule